// File: doc/BRIEF.md
# Fault Isolation Register Bank

The block gathers single-cycle error reports from neighbouring logic into a sticky 64-bit status register. Each status bit carries a mask bit and a two-bit action class, held across two action registers. Every active, unmasked status bit raises one of four attention outputs, chosen by its class: checkstop, recoverable, host attention or unit checkstop.

Software reaches the bank through a small register port with eight word offsets. The status register can be written whole, or cleared bit by bit through an AND alias. The mask register can be written whole, or set bit by bit through an OR alias. Both action registers are plainly writable. Reads return the register at the offset. Each alias reads back its base register. The two unused offsets read zero and ignore writes.

Top module: `fault_isolation_bank`

## Requirements
- R1: After reset, status, action-0 and action-1 are all zero, the mask is all ones, and all four attention outputs are low.
- R2: A one on error input bit n sets status bit n at the next rising clock edge. The bit then stays set until software clears it.
- R3: Only error input bits 0 to 17, 24 and 25 can set status. Input bits 18 to 23 and 26 to 63 are ignored.
- R4: A write at offset 0 loads the status register with the write data. A write at offset 1 loads the status with status AND write data. If a hardware error sets a bit in the same cycle that a write clears it, the bit ends up set.
- R5: A write at offset 3 loads the mask with the write data. A write at offset 5 loads the mask with mask OR write data.
- R6: A status bit that is set and unmasked raises exactly one attention output, chosen by its pair of action bits (action-0, action-1): (0,0) raises checkstop, (0,1) raises recoverable, (1,0) raises host attention, and (1,1) raises unit checkstop. Writes at offsets 6 and 7 load action-0 and action-1.
- R7: Reads at offsets 0 and 1 return the status. Reads at offsets 3 and 5 return the mask. Reads at offsets 6 and 7 return action-0 and action-1. Offsets 2 and 4 read zero, and writes to them change nothing.
- R8: The read data bus is zero whenever the bank is not selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| err_in | input | 64 | Error reports, one bit per status bit |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | Access is a write when high |
| bus_addr | input | 3 | Word offset |
| bus_wdata | input | 64 | Write data |
| bus_rdata | output | 64 | Read data, combinational |
| attn_chkstop | output | 1 | Checkstop attention |
| attn_recov | output | 1 | Recoverable attention |
| attn_host | output | 1 | Host attention |
| attn_unit_cs | output | 1 | Unit checkstop attention |

## Verification
The assertions check, on every cycle, that:
- status bits stay sticky unless a status write occurs;
- an error input reaches status on the next edge;
- the spare and undefined bits never change without a write;
- the OR alias of the mask behaves as specified;
- a fully masked bank raises no attention;
- the unused offsets read zero and change nothing.

Only the bench's scenarios show the full picture of the attention decode. This covers the mapping of each action pair to its own output, the win of an error over a simultaneous clear, and the reset contents read back over the port.

// File: rtl/fault_isolation_bank.sv
module fault_isolation_bank #(
  parameter int WIDTH     = 64,
  parameter int AW        = 3,
  parameter int DEF_BITS  = 26,
  parameter int SPARE_LO  = 18,
  parameter int SPARE_HI  = 23
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] err_in,
  input  logic             bus_sel,
  input  logic             bus_wr,
  input  logic [AW-1:0]    bus_addr,
  input  logic [WIDTH-1:0] bus_wdata,
  output logic [WIDTH-1:0] bus_rdata,
  output logic             attn_chkstop,
  output logic             attn_recov,
  output logic             attn_host,
  output logic             attn_unit_cs
);

  localparam logic [AW-1:0] OFS_STAT     = AW'(0);
  localparam logic [AW-1:0] OFS_STAT_AND = AW'(1);
  localparam logic [AW-1:0] OFS_HOLE_A   = AW'(2);
  localparam logic [AW-1:0] OFS_MASK     = AW'(3);
  localparam logic [AW-1:0] OFS_HOLE_B   = AW'(4);
  localparam logic [AW-1:0] OFS_MASK_OR  = AW'(5);
  localparam logic [AW-1:0] OFS_ACT0     = AW'(6);
  localparam logic [AW-1:0] OFS_ACT1     = AW'(7);

  function automatic logic [WIDTH-1:0] hw_settable();
    logic [WIDTH-1:0] v;
    v = '0;
    for (int i = 0; i < WIDTH; i++)
      if (i < DEF_BITS && !(i >= SPARE_LO && i <= SPARE_HI)) v[i] = 1'b1;
    return v;
  endfunction

  localparam logic [WIDTH-1:0] HW_SET = hw_settable();

  logic [WIDTH-1:0] status_q, mask_q, act0_q, act1_q;
  logic [WIDTH-1:0] status_base, mask_next;
  logic             wr_en;

  assign wr_en = bus_sel & bus_wr;

  always_comb begin
    status_base = status_q;
    if (wr_en && bus_addr == OFS_STAT)     status_base = bus_wdata;
    if (wr_en && bus_addr == OFS_STAT_AND) status_base = status_q & bus_wdata;
  end

  always_comb begin
    mask_next = mask_q;
    if (wr_en && bus_addr == OFS_MASK)    mask_next = bus_wdata;
    if (wr_en && bus_addr == OFS_MASK_OR) mask_next = mask_q | bus_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= '1;
      act0_q   <= '0;
      act1_q   <= '0;
    end else begin
      status_q <= status_base | (err_in & HW_SET);
      mask_q   <= mask_next;
      if (wr_en && bus_addr == OFS_ACT0) act0_q <= bus_wdata;
      if (wr_en && bus_addr == OFS_ACT1) act1_q <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      unique case (bus_addr)
        OFS_STAT, OFS_STAT_AND: bus_rdata = status_q;
        OFS_MASK, OFS_MASK_OR:  bus_rdata = mask_q;
        OFS_ACT0:               bus_rdata = act0_q;
        OFS_ACT1:               bus_rdata = act1_q;
        default:                bus_rdata = '0;
      endcase
    end
  end

  logic [WIDTH-1:0] live;
  assign live         = status_q & ~mask_q;
  assign attn_chkstop = |(live & ~act0_q & ~act1_q);
  assign attn_recov   = |(live & ~act0_q &  act1_q);
  assign attn_host    = |(live &  act0_q & ~act1_q);
  assign attn_unit_cs = |(live &  act0_q &  act1_q);

  logic stat_wr, hole_acc;
  assign stat_wr  = wr_en && (bus_addr == OFS_STAT || bus_addr == OFS_STAT_AND);
  assign hole_acc = bus_sel && (bus_addr == OFS_HOLE_A || bus_addr == OFS_HOLE_B);

  assert_reset_vals_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (mask_q == '1 && status_q == '0 && act0_q == '0 && act1_q == '0));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(err_in & HW_SET)) == $past(err_in & HW_SET)));

  assert_spare_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !stat_wr |=> ((status_q & ~HW_SET) == $past(status_q & ~HW_SET)));

  assert_mask_or_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && bus_addr == OFS_MASK_OR) |=> (mask_q == $past(mask_q | bus_wdata)));

  assert_all_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (&mask_q) |-> !(attn_chkstop || attn_recov || attn_host || attn_unit_cs));

  assert_one_class_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(live) == 1) |-> $onehot({attn_chkstop, attn_recov, attn_host, attn_unit_cs}));

  assert_hole_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hole_acc |-> (bus_rdata == '0));

  assert_hole_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    hole_acc |=> ($stable(mask_q) && $stable(act0_q) && $stable(act1_q)));

  assert_idle_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));

endmodule

// File: tb/fault_isolation_bank_bench.sv
module fault_isolation_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] err_in = '0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [63:0] bus_rdata;
  logic        attn_chkstop, attn_recov, attn_host, attn_unit_cs;

  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  fault_isolation_bank u_fault_isolation_bank (
    .clk(clk), .rst_n(rst_n), .err_in(err_in), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .attn_chkstop(attn_chkstop), .attn_recov(attn_recov),
    .attn_host(attn_host), .attn_unit_cs(attn_unit_cs));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] attn();
    return {60'd0, attn_chkstop, attn_recov, attn_host, attn_unit_cs};
  endfunction

  task automatic wr(input logic [2:0] a, input logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [63:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic pulse(input logic [63:0] e);
    @(negedge clk);
    err_in = e;
    @(negedge clk);
    err_in = '0;
  endtask

  task automatic t_reset();
    logic [63:0] d;
    rd(3'd0, d); chk("R1 status", d, 64'd0);
    rd(3'd3, d); chk("R1 mask", d, '1);
    rd(3'd6, d); chk("R1 act0", d, 64'd0);
    rd(3'd7, d); chk("R1 act1", d, 64'd0);
    chk("R1 attn", attn(), 64'd0);
  endtask

  task automatic t_capture();
    logic [63:0] d;
    pulse(64'h20);
    rd(3'd0, d); chk("R2 set", d, 64'h20);
    repeat (5) @(negedge clk);
    rd(3'd0, d); chk("R2 sticky", d, 64'h20);
  endtask

  task automatic t_spare();
    logic [63:0] d;
    wr(3'd0, 64'd0);
    pulse(64'h0000_0100_00FC_0004 | (64'h1 << 17) | (64'h3 << 24));
    rd(3'd0, d); chk("R3 spare ignored", d, 64'h0302_0004);
  endtask

  task automatic t_clear();
    logic [63:0] d;
    wr(3'd0, 64'h24);
    rd(3'd0, d); chk("R4 plain write", d, 64'h24);
    wr(3'd1, ~64'h20);
    rd(3'd0, d); chk("R4 and clear", d, 64'h04);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 3'd1; bus_wdata = 64'h0; err_in = 64'h80;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0; err_in = '0;
    rd(3'd0, d); chk("R4 error wins", d, 64'h80);
  endtask

  task automatic t_mask();
    logic [63:0] d;
    wr(3'd3, 64'd0);
    rd(3'd3, d); chk("R5 plain write", d, 64'd0);
    wr(3'd5, 64'h3);
    wr(3'd5, 64'h30);
    rd(3'd3, d); chk("R5 or set", d, 64'h33);
  endtask

  task automatic t_decode();
    wr(3'd3, 64'd0);
    wr(3'd6, 64'hA);
    wr(3'd7, 64'hC);
    wr(3'd0, 64'h1); #1 chk("R6 class 00 checkstop", attn(), 64'h8);
    wr(3'd0, 64'h4); #1 chk("R6 class 01 recoverable", attn(), 64'h4);
    wr(3'd0, 64'h2); #1 chk("R6 class 10 host", attn(), 64'h2);
    wr(3'd0, 64'h8); #1 chk("R6 class 11 unit cs", attn(), 64'h1);
    wr(3'd5, 64'h8); #1 chk("R6 masked", attn(), 64'h0);
  endtask

  task automatic t_holes();
    logic [63:0] d;
    wr(3'd0, 64'h55);
    wr(3'd3, 64'hF0);
    wr(3'd2, '1);
    wr(3'd4, '1);
    rd(3'd2, d); chk("R7 hole 2 reads zero", d, 64'd0);
    rd(3'd4, d); chk("R7 hole 4 reads zero", d, 64'd0);
    rd(3'd1, d); chk("R7 status alias read", d, 64'h55);
    rd(3'd5, d); chk("R7 mask alias read", d, 64'hF0);
    rd(3'd6, d); chk("R7 act0 unchanged", d, 64'hA);
    rd(3'd7, d); chk("R7 act1 unchanged", d, 64'hC);
  endtask

  task automatic t_idle();
    @(negedge clk);
    bus_sel = 1'b0; bus_addr = 3'd0;
    #1 chk("R8 idle read zero", bus_rdata, 64'd0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_capture();
    t_spare();
    t_clear();
    t_mask();
    t_decode();
    t_holes();
    t_idle();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 200000);
    checks++; fails++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule